// File: doc/BRIEF.md
# Multi-Source Set-Reset Latch Peripheral

This peripheral holds a single bit of state that any of several sources can set or clear. The sources are two comparator result lines and an external input pin, which arrive already synchronized to the system clock. A firmware set bit and a firmware clear bit act as one-shot commands. An internal divider produces a periodic strobe with a selectable period. Each source has its own enable toward the set side and toward the clear side. The enabled requests are OR-combined, and the clear side always wins a conflict. Software must put the state into a known value before it enables the outputs, because device reset does not initialize the stored bit.

The state is kept in a register on the system clock and updates on the edge after a request is present. The true value and the inverted value each have an output enable. When an output is enabled, it drives its pin line and raises the matching driver enable. When it is disabled, the line is held low and the driver enable is low. Both outputs may be enabled together. A three-register interface gives write access to the controls and read access to the stored bit.

Top module: `mslatch_top`

## Requirements
- R1: When any enabled set request and any enabled clear request are present in the same cycle, the stored bit is 0 after the next clock edge. This holds for every combination of sources, including the periodic strobe enabled toward both sides.
- R2: Register 1 holds the source enables: bit 0 lets comparator 1 set and bit 1 lets it clear; bits 2 and 3 do the same for comparator 2; bits 4 and 5 do the same for the external pin. A source whose enable bit is 0 has no effect on the stored bit.
- R3: Writing 1 to bit 5 of register 0 sets the stored bit, and writing 1 to bit 6 of register 0 clears it. Each write produces a request for exactly one cycle. Both bits always read back as 0.
- R4: Bits 2:0 of register 0 (sel) choose the period of the internal strobe. The strobe is a one-cycle pulse every 2^(sel+2) clocks, so the period ranges from 4 to 512 clocks.
- R5: Bit 6 of register 1 lets the strobe set the stored bit, and bit 7 lets it clear the stored bit.
- R6: Bit 3 of register 0 enables the true output. When it is 1, q_drv_en is 1 and q_out equals the stored bit. When it is 0, both signals are 0.
- R7: Bit 4 of register 0 enables the inverted output. When it is 1, qn_drv_en is 1 and qn_out equals the complement of the stored bit. When it is 0, both signals are 0. Both outputs may be enabled at the same time.
- R8: Reading register 2 returns the stored bit in bit 0 and zeros in all other bits. Reading register 0 returns sel in bits 2:0 and the two output enables in bits 3 and 4. Reading register 1 returns the source enables.
- R9: After reset, registers 0 and 1 read as 0, so both outputs and both driver enables are low. A request present in a cycle changes the stored bit at the next clock edge. With no request present, the stored bit holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 control, 1 source enables, 2 state |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr, combinational |
| cmp1_res | input | 1 | Synchronized comparator 1 result |
| cmp2_res | input | 1 | Synchronized comparator 2 result |
| ext_in | input | 1 | Synchronized external input pin |
| q_out | output | 1 | True output line |
| q_drv_en | output | 1 | Driver enable for the true output |
| qn_out | output | 1 | Inverted output line |
| qn_drv_en | output | 1 | Driver enable for the inverted output |

## Verification
A wrong stored bit appears on the state register and on any enabled output one clock edge after the request that caused it. The bench compares these against a cycle-level model on every cycle of randomized source activity, so an error shows within one cycle. A mistake in priority or in the source gating shows up as a 1 where the model holds 0, or the reverse, on the first cycle where the sources conflict or a disabled source is active. Divider faults show up as a wrong interval between two successive strobe-driven edges of the stored bit.

// File: rtl/mslatch_pkg.sv
package mslatch_pkg;
  parameter int unsigned SEL_W  = 3;
  parameter int unsigned ADDR_W = 2;
  parameter int unsigned DATA_W = 8;

  localparam int unsigned NUM_SRC = 4;
  localparam int unsigned EXP_OFS = 2;

  localparam logic [ADDR_W-1:0] ADR_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] ADR_SRC  = 2'd1;
  localparam logic [ADDR_W-1:0] ADR_STAT = 2'd2;

  localparam int unsigned B_OE_T  = 3;
  localparam int unsigned B_OE_N  = 4;
  localparam int unsigned B_FWSET = 5;
  localparam int unsigned B_FWCLR = 6;

  typedef enum logic [1:0] {
    SRC_CMP1 = 2'd0,
    SRC_CMP2 = 2'd1,
    SRC_PIN  = 2'd2,
    SRC_TICK = 2'd3
  } src_e;

  typedef struct packed {
    logic [NUM_SRC-1:0] set_en;
    logic [NUM_SRC-1:0] clr_en;
  } src_en_t;
endpackage

// File: rtl/mslatch_regs.sv
module mslatch_regs
  import mslatch_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              state,
  output logic [DATA_W-1:0] rdata,
  output logic [SEL_W-1:0]  sel,
  output logic              oe_t,
  output logic              oe_n,
  output src_en_t           en,
  output logic              fw_set,
  output logic              fw_clr
);
  logic [SEL_W-1:0]  sel_q, sel_d;
  logic              oet_q, oet_d, oen_q, oen_d;
  logic [DATA_W-1:0] src_q, src_d;
  logic              fws_q, fws_d, fwc_q, fwc_d;
  logic              ctrl_we, src_we;

  assign ctrl_we = wr && (addr == ADR_CTRL);
  assign src_we  = wr && (addr == ADR_SRC);

  always_comb begin
    sel_d = sel_q;
    oet_d = oet_q;
    oen_d = oen_q;
    src_d = src_q;
    fws_d = 1'b0;
    fwc_d = 1'b0;
    if (ctrl_we) begin
      sel_d = wdata[SEL_W-1:0];
      oet_d = wdata[B_OE_T];
      oen_d = wdata[B_OE_N];
      fws_d = wdata[B_FWSET];
      fwc_d = wdata[B_FWCLR];
    end
    if (src_we) src_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0;
      oet_q <= 1'b0;
      oen_q <= 1'b0;
      src_q <= '0;
      fws_q <= 1'b0;
      fwc_q <= 1'b0;
    end else begin
      sel_q <= sel_d;
      oet_q <= oet_d;
      oen_q <= oen_d;
      src_q <= src_d;
      fws_q <= fws_d;
      fwc_q <= fwc_d;
    end
  end

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_en
    assign en.set_en[i] = src_q[2*i];
    assign en.clr_en[i] = src_q[2*i+1];
  end

  always_comb begin
    rdata = '0;
    unique case (addr)
      ADR_CTRL: begin
        rdata[SEL_W-1:0] = sel_q;
        rdata[B_OE_T]    = oet_q;
        rdata[B_OE_N]    = oen_q;
      end
      ADR_SRC:  rdata = src_q;
      ADR_STAT: rdata[0] = state;
      default:  rdata = '0;
    endcase
  end

  assign sel    = sel_q;
  assign oe_t   = oet_q;
  assign oe_n   = oen_q;
  assign fw_set = fws_q;
  assign fw_clr = fwc_q;
endmodule

// File: rtl/mslatch_tick.sv
module mslatch_tick
  import mslatch_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  localparam int unsigned CNT_W = (1 << SEL_W) + EXP_OFS - 1;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] mask;
  logic [SEL_W:0]   shamt;

  assign shamt = {1'b0, sel} + (SEL_W+1)'(EXP_OFS);
  assign mask  = ~({CNT_W{1'b1}} << shamt);
  assign cnt_d = cnt_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign tick = ((cnt_q & mask) == mask);
endmodule

// File: rtl/mslatch_core.sv
module mslatch_core
  import mslatch_pkg::*;
(
  input  logic               clk,
  input  logic [NUM_SRC-1:0] src,
  input  src_en_t            en,
  input  logic               fw_set,
  input  logic               fw_clr,
  output logic               set_any,
  output logic               clr_any,
  output logic               state
);
  logic state_q, state_d;

  assign set_any = (|(src & en.set_en)) | fw_set;
  assign clr_any = (|(src & en.clr_en)) | fw_clr;

  always_comb begin
    state_d = state_q;
    if (clr_any)      state_d = 1'b0;
    else if (set_any) state_d = 1'b1;
  end

  always_ff @(posedge clk) begin
    state_q <= state_d;
  end

  assign state = state_q;
endmodule

// File: rtl/mslatch_top.sv
module mslatch_top
  import mslatch_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              cmp1_res,
  input  logic              cmp2_res,
  input  logic              ext_in,
  output logic              q_out,
  output logic              q_drv_en,
  output logic              qn_out,
  output logic              qn_drv_en
);
  logic [1:0]         rsync_q;
  logic               rst_sync_n;
  logic [SEL_W-1:0]   sel;
  logic               oe_t, oe_n;
  src_en_t            en;
  logic               fw_set, fw_clr;
  logic               tick;
  logic [NUM_SRC-1:0] src;
  logic               set_any, rst_any;
  logic               q_state;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_sync_n = rsync_q[1];

  mslatch_regs u_regs (
    .clk(clk), .rst_n(rst_sync_n), .wr(reg_wr), .addr(reg_addr),
    .wdata(reg_wdata), .state(q_state), .rdata(reg_rdata), .sel(sel),
    .oe_t(oe_t), .oe_n(oe_n), .en(en), .fw_set(fw_set), .fw_clr(fw_clr)
  );

  mslatch_tick u_tick (
    .clk(clk), .rst_n(rst_sync_n), .sel(sel), .tick(tick)
  );

  assign src[SRC_CMP1] = cmp1_res;
  assign src[SRC_CMP2] = cmp2_res;
  assign src[SRC_PIN]  = ext_in;
  assign src[SRC_TICK] = tick;

  mslatch_core u_core (
    .clk(clk), .src(src), .en(en), .fw_set(fw_set), .fw_clr(fw_clr),
    .set_any(set_any), .clr_any(rst_any), .state(q_state)
  );

  assign q_drv_en  = oe_t;
  assign qn_drv_en = oe_n;
  assign q_out     = oe_t & q_state;
  assign qn_out    = oe_n & ~q_state;
endmodule

// File: rtl/mslatch_chk.sv
module mslatch_chk
  import mslatch_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              set_any,
  input logic              rst_any,
  input logic              q,
  input logic              tick,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic              q_out,
  input logic              q_drv_en,
  input logic              qn_out,
  input logic              qn_drv_en
);
  a_r1_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (set_any && rst_any) |=> !q);
  a_r9_set_next: assert property (@(posedge clk) disable iff (!rst_n)
    (set_any && !rst_any) |=> q);
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_any && !rst_any) |=> $stable(q));
  a_r3_fw_clear_req: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == ADR_CTRL && reg_wdata[B_FWCLR]) |=> rst_any);
  a_r3_fw_set_req: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == ADR_CTRL && reg_wdata[B_FWSET]) |=> (set_any || rst_any));
  a_r4_tick_single: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
  a_r6_true_off: assert property (@(posedge clk) disable iff (!rst_n)
    !q_drv_en |-> !q_out);
  a_r7_inv_off: assert property (@(posedge clk) disable iff (!rst_n)
    !qn_drv_en |-> !qn_out);
  a_r7_both_differ: assert property (@(posedge clk) disable iff (!rst_n)
    (q_drv_en && qn_drv_en) |-> (q_out != qn_out));
endmodule

bind mslatch_top mslatch_chk u_chk (
  .clk(clk), .rst_n(rst_sync_n), .set_any(set_any), .rst_any(rst_any),
  .q(q_state), .tick(tick), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .q_out(q_out), .q_drv_en(q_drv_en),
  .qn_out(qn_out), .qn_drv_en(qn_drv_en)
);

// File: tb/sim_mslatch_top.sv
`timescale 1ns/1ps
module sim_mslatch_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       reg_wr;
  logic [1:0] reg_addr;
  logic [7:0] reg_wdata;
  logic [7:0] reg_rdata;
  logic       cmp1_res, cmp2_res, ext_in;
  logic       q_out, q_drv_en, qn_out, qn_drv_en;

  int checks = 0;
  int errors = 0;
  int unsigned cyc = 0;
  logic exp_q;
  logic [7:0] en_reg;
  logic oe_t, oe_n;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  mslatch_top u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cmp1_res(cmp1_res),
    .cmp2_res(cmp2_res), .ext_in(ext_in), .q_out(q_out), .q_drv_en(q_drv_en),
    .qn_out(qn_out), .qn_drv_en(qn_drv_en)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  function automatic logic model_next(input logic cur, input logic [7:0] en,
                                      input logic c1, input logic c2, input logic p,
                                      input logic fs, input logic fc);
    logic [3:0] s;
    logic st, cl;
    s  = {1'b0, p, c2, c1};
    st = fs;
    cl = fc;
    for (int i = 0; i < 4; i++) begin
      st |= s[i] & en[2*i];
      cl |= s[i] & en[2*i+1];
    end
    if (cl) return 1'b0;
    if (st) return 1'b1;
    return cur;
  endfunction

  task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic ctrl_cmd(input logic [2:0] sel, input logic fs, input logic fc);
    wr_reg(2'd0, {1'b0, fc, fs, oe_n, oe_t, sel});
    @(negedge clk);
  endtask

  task automatic check_outs(input string req);
    chk(req, {28'd0, q_drv_en, q_out, qn_drv_en, qn_out},
        {28'd0, oe_t, oe_t & exp_q, oe_n, oe_n & ~exp_q});
  endtask

  task automatic measure(input logic want, output int unsigned when);
    when = 0;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (q_out === want) begin when = cyc; break; end
    end
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int unsigned t0, t1;
    void'($urandom(32'h5EED_1827));
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = 2'd0; reg_wdata = 8'd0;
    cmp1_res = 1'b0; cmp2_res = 1'b0; ext_in = 1'b0;
    oe_t = 1'b0; oe_n = 1'b0; en_reg = 8'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R9 reset state
    reg_addr = 2'd0; #0.1;
    chk("R9 ctrl after reset", reg_rdata, 8'h00);
    reg_addr = 2'd1; #0.1;
    chk("R9 src after reset", reg_rdata, 8'h00);
    chk("R9 outputs after reset", {q_drv_en, q_out, qn_drv_en, qn_out}, 4'b0000);

    // R3 firmware set, clear, read-back zero; R6 R7 both outputs on
    oe_t = 1'b1; oe_n = 1'b1;
    ctrl_cmd(3'd0, 1'b0, 1'b1); exp_q = 1'b0;
    check_outs("R3 fw clear");
    reg_addr = 2'd0; #0.1;
    chk("R3 fw bits read zero", reg_rdata, 8'h18);
    ctrl_cmd(3'd0, 1'b1, 1'b0); exp_q = 1'b1;
    check_outs("R7 fw set both outputs");
    reg_addr = 2'd2; #0.1;
    chk("R8 state read", reg_rdata, 8'h01);
    ctrl_cmd(3'd0, 1'b1, 1'b1); exp_q = 1'b0;
    check_outs("R1 fw set and clear together");
    repeat (3) @(negedge clk);
    check_outs("R9 hold without request");

    // R2 disabled sources ignored
    cmp1_res = 1'b1; cmp2_res = 1'b1; ext_in = 1'b1;
    repeat (5) @(negedge clk);
    check_outs("R2 disabled sources ignored");
    cmp1_res = 1'b0; cmp2_res = 1'b0; ext_in = 1'b0;

    // R6 outputs disabled
    oe_t = 1'b0; oe_n = 1'b0;
    ctrl_cmd(3'd0, 1'b1, 1'b0); exp_q = 1'b1;
    check_outs("R6 outputs disabled");
    reg_addr = 2'd2; #0.1;
    chk("R8 state while outputs off", reg_rdata, 8'h01);

    // random source activity with model
    for (int blk = 0; blk < 8; blk++) begin
      logic [2:0] s;
      en_reg = 8'($urandom) & 8'h3F;
      oe_t = 1'($urandom); oe_n = 1'($urandom);
      s = 3'($urandom);
      wr_reg(2'd1, en_reg);
      reg_addr = 2'd1; #0.1;
      chk("R8 src read back", reg_rdata, en_reg);
      ctrl_cmd(s, 1'b0, 1'b1); exp_q = 1'b0;
      reg_addr = 2'd0; #0.1;
      chk("R8 ctrl read back", reg_rdata, {3'b000, oe_n, oe_t, s});
      reg_addr = 2'd2;
      for (int i = 0; i < 60; i++) begin
        logic c1, c2, p;
        c1 = 1'($urandom); c2 = 1'($urandom); p = 1'($urandom);
        cmp1_res = c1; cmp2_res = c2; ext_in = p;
        exp_q = model_next(exp_q, en_reg, c1, c2, p, 1'b0, 1'b0);
        @(negedge clk);
        chk("R2 R1 random state", {31'd0, reg_rdata[0]}, {31'd0, exp_q});
        check_outs("R6 R7 random outputs");
      end
      cmp1_res = 1'b0; cmp2_res = 1'b0; ext_in = 1'b0;
    end

    // directed conflict between pin set and comparator clear
    en_reg = 8'h12;
    wr_reg(2'd1, en_reg);
    oe_t = 1'b1; oe_n = 1'b0;
    ctrl_cmd(3'd0, 1'b1, 1'b0); exp_q = 1'b1;
    cmp1_res = 1'b1; ext_in = 1'b1;
    @(negedge clk); exp_q = 1'b0;
    check_outs("R1 pin set vs cmp1 clear");
    cmp1_res = 1'b0; ext_in = 1'b0;

    // R4 R5 strobe periods via set enable
    wr_reg(2'd1, 8'h40);
    for (int k = 0; k < 3; k++) begin
      logic [2:0] s;
      s = (k == 0) ? 3'd0 : (k == 1) ? 3'd2 : 3'd5;
      ctrl_cmd(s, 1'b0, 1'b1);
      measure(1'b1, t0);
      wr_reg(2'd0, {1'b0, 1'b1, 1'b0, oe_n, oe_t, s});
      measure(1'b1, t1);
      chk("R4 R5 strobe set period", t1 - t0, 32'(1) << (s + 2));
    end

    // R5 strobe clear enable
    wr_reg(2'd1, 8'h80);
    ctrl_cmd(3'd1, 1'b1, 1'b0);
    measure(1'b0, t0);
    wr_reg(2'd0, {1'b0, 1'b0, 1'b1, oe_n, oe_t, 3'd1});
    measure(1'b0, t1);
    chk("R5 strobe clear period", t1 - t0, 32'd8);

    // R1 strobe to both sides keeps cleared
    wr_reg(2'd1, 8'hC0);
    ctrl_cmd(3'd0, 1'b0, 1'b1); exp_q = 1'b0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      check_outs("R1 strobe on both sides");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule